// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block decides how long each external bus access lasts. A requester raises a one-cycle request together with an address and a read/write flag. The controller then drives an active-low bus strobe and one of four active-low page selects for the whole access. It ends the access with a one-cycle internal ready pulse. The length of the access comes from three sources: a slow, active-low external ready input, a programmable internal wait count, and a bank comparator. The comparator can add one idle cycle before a read that leaves the bank of the previous access.

A mode bit selects how the external ready and the internal count combine. In AND mode, either source can end the access: a ready external device ends it at once, and otherwise the count ends it. In OR mode, both sources must agree: the access lasts at least the programmed count and is stretched for as long as the external device is not ready. The external ready passes through a two-flop synchronizer before it is used. The whole block runs on a single clock. The previous-access address register is updated when an access completes.

Top module: `bus_wait_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, `strb_n_o` is 1, every bit of `page_n_o` is 1 and `bus_ready_o` is 0. `bus_ready_o` is high only during the last cycle of an access, which is a cycle with `strb_n_o` low.
- R2: In AND mode (`or_mode_i`=0), when the synchronized `ready_n_i` is 0, the access lasts exactly one cycle of `strb_n_o` low, whatever the wait count.
- R3: In AND mode, when the synchronized `ready_n_i` is 1, a wait count W (0..7) gives an access of exactly W+1 cycles.
- R4: In OR mode (`or_mode_i`=1), when the synchronized `ready_n_i` is 0, a wait count W gives an access of exactly W+1 cycles.
- R5: In OR mode, an access never ends before W+1 cycles and does not end while the synchronized `ready_n_i` is 1. After `ready_n_i` falls, the access ends in the second cycle, counted from the driving edge, once W+1 cycles have passed.
- R6: With `bank_bits_i`=N (N>0), bank compare is on. It compares the top min(N,24) address bits with the address of the last completed access. A read whose bits differ is preceded by exactly one idle cycle, during which `strb_n_o` is 1 and all page selects are 1. N=0 turns the compare off.
- R7: A write is never preceded by an idle cycle, even when it changes bank.
- R8: While `strb_n_o` is 0, `page_n_o[k]` is 0 for k = address bits [23:22] of the access, and every other bit is 1.
- R9: Reset clears the stored previous address. With compare on, the first read after reset always gets the idle cycle.
- R10: A request raised while an access or an idle cycle is in progress is ignored. Each completed access is followed by at least one cycle with `strb_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle access request, accepted only when idle |
| addr_i | input | 24 | Access address, captured with the request |
| rnw_i | input | 1 | 1 = read, 0 = write |
| ready_n_i | input | 1 | External ready, active low, asynchronous |
| wait_cnt_i | input | 3 | Programmed wait count 0..7 |
| bank_bits_i | input | 5 | Number of upper address bits compared; 0 turns compare off |
| or_mode_i | input | 1 | 0 = AND combination, 1 = OR combination |
| bus_ready_o | output | 1 | High in the final cycle of an access |
| strb_n_o | output | 1 | Active-low bus strobe |
| page_n_o | output | 4 | Active-low page selects decoded from address bits [23:22] |

## Verification
The main function is driven from a table. The table mixes both combination modes, both external ready levels held steady, wait counts from 0 to 7, reads and writes, and compare widths of 0, 2, 8 and 24 bits. Access length and idle-cycle count are measured at the pins. The cases are chosen in pairs: a ready device against a counted access shows whether AND mode lets the pin override the count; the same count under OR mode shows it does not; and a write against a read to a new bank separates the pre-extension rule. Directed runs cover ready held high in OR mode and then released, a request raised mid-access, and a reset followed by a read that matches the old address.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;

    localparam int ADDR_W    = 24;
    localparam int WAIT_W    = 3;
    localparam int BANKSEL_W = 5;
    localparam int PAGE_BITS = 2;
    localparam int SYNC_LEN  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NULL   = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic [WAIT_W-1:0] wait_cnt;
    } bus_req_t;

    // Decide whether the current access cycle may finish.
    function automatic logic cycle_done(input logic or_mode,
                                        input logic ext_ready,
                                        input logic cnt_expired);
        if (or_mode)
            return ext_ready && cnt_expired;
        else
            return ext_ready || cnt_expired;
    endfunction

endpackage

// File: rtl/bus_wait_sync.sv
module bus_wait_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= {STAGES{RESET_VAL}};
        else
            chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bus_wait_counter.sv
module bus_wait_counter #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (dec_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bus_wait_bank.sv
module bus_wait_bank #(
    parameter int ADDR_W = 24,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEL_W-1:0]  nbits_i,
    input  logic              store_i,
    input  logic [ADDR_W-1:0] store_addr_i,
    output logic              enabled_o,
    output logic              mismatch_o
);
    logic [ADDR_W-1:0] prev_q;
    logic              prev_valid_q;
    logic [ADDR_W-1:0] mask;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign mask[i] = ((32'(nbits_i) + 32'(i)) >= 32'(ADDR_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q       <= '0;
            prev_valid_q <= 1'b0;
        end else if (store_i) begin
            prev_q       <= store_addr_i;
            prev_valid_q <= 1'b1;
        end
    end

    assign enabled_o  = (nbits_i != '0);
    assign mismatch_o = !prev_valid_q || (((addr_i ^ prev_q) & mask) != '0);
endmodule

// File: rtl/bus_wait_page.sv
module bus_wait_page #(
    parameter int SEL_BITS = 2,
    localparam int PAGES   = 1 << SEL_BITS
) (
    input  logic                en_i,
    input  logic [SEL_BITS-1:0] sel_i,
    output logic [PAGES-1:0]    page_n_o
);
    for (genvar k = 0; k < PAGES; k++) begin : g_page
        assign page_n_o[k] = !(en_i && (sel_i == SEL_BITS'(k)));
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bus_wait_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int WW     = WAIT_W,
    parameter int SW     = BANKSEL_W,
    parameter int PB     = PAGE_BITS,
    localparam int NPAGE = 1 << PB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             rnw_i,
    input  logic             ready_n_i,
    input  logic [WW-1:0]    wait_cnt_i,
    input  logic [SW-1:0]    bank_bits_i,
    input  logic             or_mode_i,
    output logic             bus_ready_o,
    output logic             strb_n_o,
    output logic [NPAGE-1:0] page_n_o
);
    bus_state_e state_q, state_d;

    logic [AW-1:0] cap_addr_q;
    logic          cap_rnw_q;
    logic [WW-1:0] cap_wait_q;

    logic ready_n_sync;
    logic cnt_zero;
    logic bank_en, bank_miss;
    logic accept, go_null, in_access, null_act, done;
    logic cnt_load;
    logic [WW-1:0] cnt_load_val;

    bus_wait_sync #(.STAGES(SYNC_LEN), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ready_n_i),
        .q_o (ready_n_sync)
    );

    bus_wait_bank #(.ADDR_W(AW), .SEL_W(SW)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .nbits_i      (bank_bits_i),
        .store_i      (done),
        .store_addr_i (cap_addr_q),
        .enabled_o    (bank_en),
        .mismatch_o   (bank_miss)
    );

    assign in_access = (state_q == ST_ACCESS);
    assign null_act  = (state_q == ST_NULL);
    assign accept    = (state_q == ST_IDLE) && req_i;
    assign go_null   = rnw_i && bank_en && bank_miss;
    assign done      = in_access && cycle_done(or_mode_i, !ready_n_sync, cnt_zero);

    assign cnt_load     = (accept && !go_null) || null_act;
    assign cnt_load_val = null_act ? cap_wait_q : wait_cnt_i;

    bus_wait_counter #(.WIDTH(WW)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .dec_i      (in_access),
        .zero_o     (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = go_null ? ST_NULL : ST_ACCESS;
            ST_NULL:   state_d = ST_ACCESS;
            ST_ACCESS: if (done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cap_addr_q <= '0;
            cap_rnw_q  <= 1'b0;
            cap_wait_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cap_addr_q <= addr_i;
                cap_rnw_q  <= rnw_i;
                cap_wait_q <= wait_cnt_i;
            end
        end
    end

    bus_wait_page #(.SEL_BITS(PB)) u_page (
        .en_i     (in_access),
        .sel_i    (cap_addr_q[AW-1 -: PB]),
        .page_n_o (page_n_o)
    );

    assign strb_n_o    = !in_access;
    assign bus_ready_o = done;
endmodule

// File: rtl/bus_wait_ctrl_chk.sv
module bus_wait_ctrl_chk #(
    parameter int NPAGE = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             strb_n_o,
    input logic             bus_ready_o,
    input logic [NPAGE-1:0] page_n_o,
    input logic             or_mode_i,
    input logic             null_act,
    input logic             cap_rnw,
    input logic             cnt_zero
);
    p_ready_in_access_r1: assert property (@(posedge clk) disable iff (rst)
        bus_ready_o |-> !strb_n_o);

    p_or_min_len_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_ready_o && or_mode_i) |-> cnt_zero);

    p_null_then_access_r6: assert property (@(posedge clk) disable iff (rst)
        null_act |=> !strb_n_o);

    p_null_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        null_act |-> (strb_n_o && (&page_n_o)));

    p_null_reads_only_r7: assert property (@(posedge clk) disable iff (rst)
        null_act |-> cap_rnw);

    p_pages_idle_r8: assert property (@(posedge clk) disable iff (rst)
        strb_n_o |-> (&page_n_o));

    p_page_single_r8: assert property (@(posedge clk) disable iff (rst)
        !strb_n_o |-> ($countones(~page_n_o) == 1));

    p_gap_after_end_r10: assert property (@(posedge clk) disable iff (rst)
        bus_ready_o |=> strb_n_o);
endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk #(.NPAGE(NPAGE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strb_n_o    (strb_n_o),
    .bus_ready_o (bus_ready_o),
    .page_n_o    (page_n_o),
    .or_mode_i   (or_mode_i),
    .null_act    (null_act),
    .cap_rnw     (cap_rnw_q),
    .cnt_zero    (cnt_zero)
);

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        rnw_i = 1'b0;
    logic        ready_n_i = 1'b1;
    logic [2:0]  wait_cnt_i = '0;
    logic [4:0]  bank_bits_i = '0;
    logic        or_mode_i = 1'b0;
    logic        bus_ready_o;
    logic        strb_n_o;
    logic [3:0]  page_n_o;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    logic [23:0] m_prev = '0;
    bit          m_valid = 0;

    always #10 clk = ~clk;

    bus_wait_ctrl u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .rnw_i(rnw_i),
        .ready_n_i(ready_n_i), .wait_cnt_i(wait_cnt_i), .bank_bits_i(bank_bits_i),
        .or_mode_i(or_mode_i), .bus_ready_o(bus_ready_o), .strb_n_o(strb_n_o),
        .page_n_o(page_n_o)
    );

    typedef struct packed {
        logic        orm;
        logic        rdyn;
        logic [2:0]  w;
        logic        rnw;
        logic [4:0]  bank;
        logic [23:0] addr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'd3, 1'b1, 5'd2,  24'h400010},
        '{1'b0, 1'b1, 3'd3, 1'b1, 5'd2,  24'h400020},
        '{1'b0, 1'b1, 3'd0, 1'b1, 5'd2,  24'hC00000},
        '{1'b0, 1'b1, 3'd5, 1'b0, 5'd2,  24'h000100},
        '{1'b1, 1'b0, 3'd2, 1'b1, 5'd2,  24'h000200},
        '{1'b1, 1'b0, 3'd0, 1'b1, 5'd8,  24'h810000},
        '{1'b1, 1'b0, 3'd7, 1'b1, 5'd0,  24'h400000},
        '{1'b0, 1'b0, 3'd7, 1'b0, 5'd24, 24'h123456},
        '{1'b0, 1'b1, 3'd1, 1'b1, 5'd24, 24'h123457},
        '{1'b1, 1'b0, 3'd4, 1'b1, 5'd24, 24'h123457}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_nulls(input logic rnw, input logic [4:0] nb,
                                     input logic [23:0] a);
        logic [23:0] m;
        for (int i = 0; i < 24; i++) m[i] = ((int'(nb) + i) >= 24);
        if (!rnw || nb == 0) return 0;
        if (!m_valid) return 1;
        return (((a ^ m_prev) & m) != 0) ? 1 : 0;
    endfunction

    function automatic int exp_len(input logic orm, input logic rdyn, input logic [2:0] w);
        if (!orm && !rdyn) return 1;
        return int'(w) + 1;
    endfunction

    // Runs one access; poke_at >= 1 raises a stray request at that access cycle.
    task automatic run_access(input vec_t v, input string tag, input int poke_at);
        int nulls;
        int len;
        int en;
        int el;
        bit fin;
        en = exp_nulls(v.rnw, v.bank, v.addr);
        el = exp_len(v.orm, v.rdyn, v.w);
        @(negedge clk);
        or_mode_i = v.orm; ready_n_i = v.rdyn; wait_cnt_i = v.w;
        rnw_i = v.rnw; bank_bits_i = v.bank; addr_i = v.addr;
        repeat (4) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        nulls = 0; len = 0; fin = 0;
        for (int k = 0; k < 40 && !fin; k++) begin
            if (strb_n_o) begin
                nulls++;
                check(page_n_o == 4'hF, "R6", "pages during idle cycle", page_n_o, 15);
            end else begin
                len++;
                if (len == 1)
                    check(page_n_o == ~(4'b0001 << v.addr[23:22]), "R8", "page select",
                          page_n_o, ~(4'b0001 << v.addr[23:22]) & 4'hF);
                if (bus_ready_o) fin = 1;
            end
            if (!fin) begin
                if (poke_at > 0 && len == poke_at) begin
                    req_i = 1'b1; addr_i = 24'hFFFFFF; rnw_i = 1'b1;
                end else req_i = 1'b0;
                @(negedge clk);
            end
        end
        req_i = 1'b0;
        check(nulls == en, (v.rnw ? "R6" : "R7"), {tag, " idle cycles"}, nulls, en);
        check(len == el, (v.orm ? "R4" : (v.rdyn ? "R3" : "R2")), {tag, " length"}, len, el);
        m_prev = v.addr; m_valid = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(strb_n_o && !bus_ready_o, "R10", {tag, " idle after access"}, strb_n_o, 1);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        vec_t v;
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(strb_n_o == 1'b1, "R1", "strobe after reset", strb_n_o, 1);
        check(page_n_o == 4'hF, "R1", "pages after reset", page_n_o, 15);
        check(bus_ready_o == 1'b0, "R1", "ready after reset", bus_ready_o, 0);

        for (int i = 0; i < NV; i++) run_access(VECS[i], $sformatf("vec%0d", i), 0);

        // R10 stray request during access
        v = '{1'b0, 1'b1, 3'd4, 1'b0, 5'd0, 24'h800004};
        run_access(v, "busy request", 2);

        // R5 OR mode held off by external device
        @(negedge clk);
        or_mode_i = 1'b1; ready_n_i = 1'b1; wait_cnt_i = 3'd2;
        rnw_i = 1'b0; bank_bits_i = 5'd0; addr_i = 24'h400000;
        repeat (4) @(negedge clk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        for (int j = 0; j < 10; j++) begin
            check(!strb_n_o && !bus_ready_o, "R5", "held while not ready", bus_ready_o, 0);
            @(negedge clk);
        end
        ready_n_i = 1'b0;
        k = 0;
        for (int j = 1; j <= 6 && k == 0; j++) begin
            @(negedge clk);
            if (bus_ready_o) k = j;
        end
        check(k == 2, "R5", "end after ready release", k, 2);
        @(negedge clk);
        check(strb_n_o == 1'b1, "R5", "idle after stretched access", strb_n_o, 1);
        m_prev = 24'h400000;

        // R9 reset forgets the previous address
        v = '{1'b0, 1'b0, 3'd0, 1'b1, 5'd2, 24'h400000};
        run_access(v, "same-bank read", 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_valid = 0;
        check(strb_n_o && (page_n_o == 4'hF), "R1", "idle after mid reset", strb_n_o, 1);
        run_access(v, "R9 first read after reset", 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule